// File: doc/BRIEF.md
# Endpoint DMA Slave Handshake Controller

This block is the slave side of a fly-by DMA link between one selected endpoint buffer and an external DMA controller. It raises a request when the selected buffer can take part in a transfer. An OUT buffer can take part when it holds data, and an IN buffer can take part when it has free space. The block then counts the transfers that the controller strobes in, and it drives single-unit read or write pulses into the buffer. The request, acknowledge and end-of-transfer pins each have their own programmable active level.

A transfer can be strobed in two ways. In strobe-qualified mode, the RD or WR strobe is qualified by the acknowledge. In acknowledge-strobe mode, the acknowledge alone is the strobe. Requests are issued either one transfer at a time or in bursts of up to 16 bytes. The bus is either 8 or 16 bits wide, and a 16-bit word takes two bytes off the byte counter.

A run ends in one of four ways:
- The counter reaches the programmed byte count.
- An external end-of-transfer is signalled.
- A short packet is drained from an OUT buffer.
- Software clears the enable.

Each cause has its own effect on the buffer: a discard, a commit of a partial packet, or nothing. Only the first three causes raise an interrupt pulse.

The control state machine has four states:
- IDLE: disabled.
- WAIT: enabled, with the request inactive.
- REQ: the request is active.
- HALT: terminated, waiting for the enable to drop.

It moves through these transitions:
- IDLE to WAIT when the enable is set. This transition also loads the counter.
- WAIT to REQ when the buffer is ready and the strobe is idle.
- REQ to WAIT when a burst is complete, or when the buffer is no longer ready.
- WAIT or REQ to HALT on an end-of-transfer cause.
- Any state to IDLE when the enable is cleared.

Top module: `ep_dma_slave`

## Requirements
- R1: After reset, dreq is at its inactive level and buf_rd, buf_wr, buf_flush, buf_commit and irq_eot are all 0.
- R2: dreq is active only while cfg_en is 1 and the selected buffer is ready. For OUT (cfg_dir_in=0), ready means buf_has_data=1. For IN (cfg_dir_in=1), ready means buf_has_space=1.
- R3: The active level of dreq, dack and eot equals pol_dreq, pol_dack and pol_eot respectively (1 = active high, 0 = active low).
- R4: With cfg_ack_only=0, a transfer is the rising edge of dack active AND rd_stb (OUT) or wr_stb (IN). The other strobe, or a strobe without dack, is ignored. Each transfer gives exactly one buf_rd (OUT) or buf_wr (IN) pulse, one cycle wide, in the cycle after the sampling edge.
- R5: With cfg_ack_only=1, the rising edge of dack active is the transfer and rd_stb/wr_stb are ignored.
- R6: With cfg_burst=0, dreq goes inactive after every transfer. It returns once the strobe is idle and the buffer is ready.
- R7: With cfg_burst=1, dreq stays active for 16 transfers on an 8-bit bus (cfg_wide=0) or 8 on a 16-bit bus (cfg_wide=1). It then drops for at least one cycle.
- R8: The byte counter is loaded from cfg_count when cfg_en rises. Each transfer lowers it by 1 (8-bit) or 2 (16-bit). With cfg_cnt_en=1, the transfer that uses up the count ends the run and pulses irq_eot with the data pulse.
- R9: When the count ends a run on IN and that last write did not fill the buffer (buf_last=0), buf_commit pulses. With buf_last=1, no commit is issued.
- R10: An active eot on OUT stops the run, with buf_flush and irq_eot pulsing together and no data pulse.
- R11: An active eot on IN stops the run, with buf_commit and irq_eot pulsing together.
- R12: With cfg_short_en=1 on OUT, a transfer taken while buf_short=1 and buf_last=1 ends the run after that transfer, with irq_eot. With cfg_short_en=0, the run continues.
- R13: Clearing cfg_en stops the run at once, with dreq inactive and no irq_eot, buf_flush or buf_commit. Setting it again restarts the run with a freshly loaded count.
- R14: After a run ends, dreq stays inactive and strobes are ignored until cfg_en is cleared and set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | DMA enable |
| cfg_cnt_en | input | 1 | Byte counter ends the run |
| cfg_short_en | input | 1 | Short OUT packet ends the run |
| cfg_ack_only | input | 1 | 1: acknowledge is the strobe; 0: RD/WR qualified by acknowledge |
| cfg_burst | input | 1 | 1: burst requests; 0: single requests |
| cfg_wide | input | 1 | 1: 16-bit bus; 0: 8-bit bus |
| cfg_dir_in | input | 1 | 1: IN endpoint (buffer written); 0: OUT (buffer read) |
| cfg_count | input | CNT_W | Programmed byte count |
| pol_dreq | input | 1 | Active level of dreq |
| pol_dack | input | 1 | Active level of dack |
| pol_eot | input | 1 | Active level of eot |
| dreq | output | 1 | DMA request |
| dack | input | 1 | DMA acknowledge |
| eot | input | 1 | External end of transfer |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| buf_has_data | input | 1 | Selected OUT buffer holds data |
| buf_has_space | input | 1 | Selected IN buffer has room |
| buf_last | input | 1 | Current transfer is the last unit of the buffer |
| buf_short | input | 1 | Current OUT packet is short |
| buf_rd | output | 1 | Pop one unit from the OUT buffer |
| buf_wr | output | 1 | Push one unit into the IN buffer |
| buf_flush | output | 1 | Discard the active OUT buffer |
| buf_commit | output | 1 | Commit the partial IN buffer for sending |
| irq_eot | output | 1 | End-of-transfer interrupt pulse |

## Verification
The hardest situation to reach is the end of a burst on a 16-bit bus with active-low pins in acknowledge-strobe mode. Reaching it needs the right combination of polarity, mode, width and burst settings, followed by an exact run of eight acknowledge pulses. The bench gets there by changing the pin polarities only while the block is disabled. It then strobes eight acknowledges back to back and samples dreq after each one. An external end-of-transfer is raised immediately after the burst, so the commit lands on an IN buffer that is only partly filled.

// File: rtl/epdma_pkg.sv
package epdma_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WAIT = 2'd1,
        S_REQ  = 2'd2,
        S_HALT = 2'd3
    } dma_state_e;
endpackage

// File: rtl/epdma_strobe.sv
module epdma_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic dack,
    input  logic eot,
    input  logic rd_stb,
    input  logic wr_stb,
    input  logic pol_dack,
    input  logic pol_eot,
    input  logic ack_only,
    input  logic dir_in,
    output logic xfer,
    output logic strobe_idle,
    output logic eot_act
);
    logic dack_act;
    logic sel;
    logic sel_q;

    assign dack_act = pol_dack ? dack : ~dack;
    assign eot_act  = pol_eot ? eot : ~eot;
    // Qualified data strobe for the chosen scheme
    assign sel = ack_only ? dack_act : (dack_act & (dir_in ? wr_stb : rd_stb));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= 1'b0;
        else        sel_q <= sel;
    end

    assign xfer        = sel & ~sel_q;
    assign strobe_idle = ~sel;
endmodule

// File: rtl/epdma_count.sv
module epdma_count #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    input  logic             wide,
    output logic             at_end
);
    logic [CNT_W-1:0] rem_q;
    logic [CNT_W-1:0] step;

    assign step   = wide ? CNT_W'(2) : CNT_W'(1);
    assign at_end = (rem_q <= step);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rem_q <= '0;
        else if (load) rem_q <= load_val;
        else if (dec)  rem_q <= (rem_q > step) ? (rem_q - step) : '0;
    end

    // R8
    count_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (rem_q <= $past(rem_q)));
endmodule

// File: rtl/epdma_fsm.sv
module epdma_fsm
    import epdma_pkg::*;
#(
    parameter int unsigned BURST_BYTES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       cnt_en,
    input  logic       short_en,
    input  logic       burst,
    input  logic       wide,
    input  logic       dir_in,
    input  logic       ready,
    input  logic       xfer,
    input  logic       strobe_idle,
    input  logic       eot_act,
    input  logic       cnt_at_end,
    input  logic       buf_last,
    input  logic       buf_short,
    output dma_state_e state,
    output logic       load,
    output logic       accept,
    output logic       buf_rd,
    output logic       buf_wr,
    output logic       buf_flush,
    output logic       buf_commit,
    output logic       irq_eot
);
    localparam int unsigned BEAT_W = $clog2(BURST_BYTES + 1);
    localparam logic [BEAT_W-1:0] BEATS_NARROW = BEAT_W'(BURST_BYTES);
    localparam logic [BEAT_W-1:0] BEATS_WIDE   = BEAT_W'(BURST_BYTES / 2);

    dma_state_e        state_q, state_d;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] burst_beats;
    logic              stop_eot, stop_cnt, stop_short;

    assign burst_beats = burst ? (wide ? BEATS_WIDE : BEATS_NARROW) : BEAT_W'(1);
    assign state = state_q;
    assign load  = (state_q == S_IDLE) && en;

    always_comb begin
        state_d    = state_q;
        accept     = 1'b0;
        stop_eot   = 1'b0;
        stop_cnt   = 1'b0;
        stop_short = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (en) state_d = S_WAIT;
            end
            S_WAIT: begin
                if (!en)                       state_d = S_IDLE;
                else if (eot_act)              begin stop_eot = 1'b1; state_d = S_HALT; end
                else if (ready && strobe_idle) state_d = S_REQ;
            end
            S_REQ: begin
                if (!en) state_d = S_IDLE;
                else if (eot_act) begin
                    stop_eot = 1'b1;
                    state_d  = S_HALT;
                end else if (xfer) begin
                    accept     = 1'b1;
                    stop_cnt   = cnt_en && cnt_at_end;
                    stop_short = short_en && !dir_in && buf_last && buf_short;
                    if (stop_cnt || stop_short)                 state_d = S_HALT;
                    else if (beat_q == burst_beats - BEAT_W'(1)) state_d = S_WAIT;
                    else if (!ready)                            state_d = S_WAIT;
                end else if (!ready) begin
                    state_d = S_WAIT;
                end
            end
            S_HALT: begin
                if (!en) state_d = S_IDLE;
            end
        endcase
    end

    // State register and beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != S_REQ) beat_q <= '0;
            else if (accept)      beat_q <= beat_q + BEAT_W'(1);
        end
    end

    // Registered buffer-side and interrupt pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_rd     <= 1'b0;
            buf_wr     <= 1'b0;
            buf_flush  <= 1'b0;
            buf_commit <= 1'b0;
            irq_eot    <= 1'b0;
        end else begin
            buf_rd     <= accept && !dir_in;
            buf_wr     <= accept && dir_in;
            buf_flush  <= stop_eot && !dir_in;
            buf_commit <= dir_in && (stop_eot || (stop_cnt && !buf_last));
            irq_eot    <= stop_eot || stop_cnt || stop_short;
        end
    end

    // R6
    single_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !burst) |=> (state_q != S_REQ));
    // R14
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HALT && en) |=> (state_q == S_HALT));
    // R13
    disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!irq_eot && !buf_flush && !buf_commit));
    // R10
    flush_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_flush |-> irq_eot);
endmodule

// File: rtl/ep_dma_slave.sv
module ep_dma_slave
    import epdma_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned BURST_BYTES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_cnt_en,
    input  logic             cfg_short_en,
    input  logic             cfg_ack_only,
    input  logic             cfg_burst,
    input  logic             cfg_wide,
    input  logic             cfg_dir_in,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             pol_dreq,
    input  logic             pol_dack,
    input  logic             pol_eot,
    output logic             dreq,
    input  logic             dack,
    input  logic             eot,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic             buf_has_data,
    input  logic             buf_has_space,
    input  logic             buf_last,
    input  logic             buf_short,
    output logic             buf_rd,
    output logic             buf_wr,
    output logic             buf_flush,
    output logic             buf_commit,
    output logic             irq_eot
);
    dma_state_e state;
    logic xfer, strobe_idle, eot_act;
    logic load, accept, at_end, ready;

    assign ready = cfg_dir_in ? buf_has_space : buf_has_data;
    assign dreq  = (state == S_REQ) ? pol_dreq : ~pol_dreq;

    epdma_strobe u_strobe (
        .clk(clk), .rst_n(rst_n), .dack(dack), .eot(eot),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .pol_dack(pol_dack),
        .pol_eot(pol_eot), .ack_only(cfg_ack_only), .dir_in(cfg_dir_in),
        .xfer(xfer), .strobe_idle(strobe_idle), .eot_act(eot_act)
    );

    epdma_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(cfg_count),
        .dec(accept), .wide(cfg_wide), .at_end(at_end)
    );

    epdma_fsm #(.BURST_BYTES(BURST_BYTES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(cfg_en), .cnt_en(cfg_cnt_en),
        .short_en(cfg_short_en), .burst(cfg_burst), .wide(cfg_wide),
        .dir_in(cfg_dir_in), .ready(ready), .xfer(xfer),
        .strobe_idle(strobe_idle), .eot_act(eot_act), .cnt_at_end(at_end),
        .buf_last(buf_last), .buf_short(buf_short), .state(state),
        .load(load), .accept(accept), .buf_rd(buf_rd), .buf_wr(buf_wr),
        .buf_flush(buf_flush), .buf_commit(buf_commit), .irq_eot(irq_eot)
    );

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({buf_rd, buf_wr, buf_flush}));
    // R11
    commit_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_commit |-> ($past(cfg_dir_in) && irq_eot));
endmodule

// File: tb/tb_ep_dma_slave.sv
`timescale 1ns/1ps
module tb_ep_dma_slave;
    localparam int CNT_W = 16;
    localparam int EV_RD = 1, EV_WR = 2, EV_FLUSH = 3, EV_COMMIT = 4, EV_IRQ = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 0, cfg_cnt_en = 0, cfg_short_en = 0, cfg_ack_only = 0;
    logic cfg_burst = 0, cfg_wide = 0, cfg_dir_in = 0;
    logic [CNT_W-1:0] cfg_count = '0;
    logic pol_dreq = 1, pol_dack = 1, pol_eot = 1;
    logic dack = 0, eot = 0, rd_stb = 0, wr_stb = 0;
    logic buf_has_data = 1, buf_has_space = 1, buf_last = 0, buf_short = 0;
    logic dreq, buf_rd, buf_wr, buf_flush, buf_commit, irq_eot;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;
    int    exp_code[$];
    string exp_req[$];

    always #2.5 clk = ~clk;

    ep_dma_slave #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_cnt_en(cfg_cnt_en),
        .cfg_short_en(cfg_short_en), .cfg_ack_only(cfg_ack_only),
        .cfg_burst(cfg_burst), .cfg_wide(cfg_wide), .cfg_dir_in(cfg_dir_in),
        .cfg_count(cfg_count), .pol_dreq(pol_dreq), .pol_dack(pol_dack),
        .pol_eot(pol_eot), .dreq(dreq), .dack(dack), .eot(eot),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .buf_has_data(buf_has_data),
        .buf_has_space(buf_has_space), .buf_last(buf_last),
        .buf_short(buf_short), .buf_rd(buf_rd), .buf_wr(buf_wr),
        .buf_flush(buf_flush), .buf_commit(buf_commit), .irq_eot(irq_eot)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int dreq_on();
        return (dreq == pol_dreq) ? 1 : 0;
    endfunction

    task automatic expect_ev(input int code, input string req);
        exp_code.push_back(code);
        exp_req.push_back(req);
    endtask

    task automatic seen(input int code);
        if (exp_code.size() == 0) begin
            check("unexpected event", code, 0);
        end else begin
            int    c = exp_code.pop_front();
            string r = exp_req.pop_front();
            check(r, code, c);
        end
    endtask

    // Monitor: pops expected buffer/interrupt events as the outputs pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (buf_rd)     seen(EV_RD);
            if (buf_wr)     seen(EV_WR);
            if (buf_flush)  seen(EV_FLUSH);
            if (buf_commit) seen(EV_COMMIT);
            if (irq_eot)    seen(EV_IRQ);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic req_check(input string req, input int want);
        check(req, dreq_on(), want);
    endtask

    // Drive strobes for two cycles; optionally check dreq after the sampling edge
    task automatic strobe(input logic r, input logic w, input logic a,
                          input int want, input string req);
        @(posedge clk); #1;
        rd_stb = r; wr_stb = w; dack = a ? pol_dack : ~pol_dack;
        @(posedge clk);
        @(negedge clk);
        if (want >= 0) req_check(req, want);
        @(posedge clk); #1;
        rd_stb = 0; wr_stb = 0; dack = ~pol_dack;
    endtask

    task automatic pulse_eot();
        @(posedge clk); #1;
        eot = pol_eot;
        @(posedge clk); #1;
        eot = ~pol_eot;
    endtask

    task automatic set_en(input logic v);
        @(posedge clk); #1;
        cfg_en = v;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        idle(2);
        // R1 reset state
        check("R1 dreq", dreq_on(), 0);
        check("R1 pulses", {buf_rd, buf_wr, buf_flush, buf_commit, irq_eot}, 0);
        // R2 not enabled even though buffer ready
        req_check("R2 disabled", 0);

        // 8-bit OUT, strobe-qualified, single, count 3
        cfg_dir_in = 0; cfg_cnt_en = 1; cfg_count = 3;
        set_en(1);
        idle(3);
        req_check("R2 ready", 1);
        strobe(0, 1, 1, 1, "R4 wrong strobe ignored");
        strobe(1, 0, 0, 1, "R4 no dack ignored");
        expect_ev(EV_RD, "R4 rd");
        strobe(1, 0, 1, 0, "R6 drop after single");
        idle(1);
        req_check("R6 re-request", 1);
        expect_ev(EV_RD, "R8 rd");
        strobe(1, 0, 1, 0, "R6 drop");
        expect_ev(EV_RD, "R8 rd last");
        expect_ev(EV_IRQ, "R8 count irq");
        strobe(1, 0, 1, 0, "R8 count end");
        idle(3);
        req_check("R14 held", 0);
        strobe(1, 0, 1, 0, "R14 strobe ignored");
        idle(2);
        set_en(0);
        idle(2);

        // R2 buffer empty
        cfg_cnt_en = 0; buf_has_data = 0;
        set_en(1);
        idle(4);
        req_check("R2 empty", 0);
        buf_has_data = 1;
        idle(3);
        req_check("R2 data arrives", 1);
        expect_ev(EV_RD, "R13 rd before disable");
        strobe(1, 0, 1, 0, "R6 drop");
        idle(1);
        set_en(0);
        idle(2);
        req_check("R13 disabled", 0);
        strobe(1, 0, 1, 0, "R13 strobe ignored");
        cfg_cnt_en = 1; cfg_count = 1;
        set_en(1);
        idle(3);
        req_check("R13 restart", 1);
        expect_ev(EV_RD, "R13 rd");
        expect_ev(EV_IRQ, "R13 fresh count");
        strobe(1, 0, 1, 0, "R13 ends on reloaded count");
        set_en(0);
        idle(2);

        // Active-low pins, acknowledge-strobe, 16-bit IN burst
        dack = 0; eot = 1;
        pol_dreq = 0; pol_dack = 0; pol_eot = 0;
        cfg_ack_only = 1; cfg_dir_in = 1; cfg_wide = 1; cfg_burst = 1; cfg_cnt_en = 0;
        buf_last = 0;
        idle(2);
        check("R3 inactive high", dreq, 1);
        dack = 1;
        set_en(1);
        idle(3);
        check("R3 active low", dreq, 0);
        strobe(1, 1, 0, 1, "R5 rd/wr ignored");
        for (int i = 0; i < 8; i++) begin
            expect_ev(EV_WR, "R5 wr");
            strobe(0, 0, 1, (i < 7) ? 1 : 0, "R7 burst of 8 words");
        end
        idle(1);
        req_check("R7 next burst", 1);
        expect_ev(EV_COMMIT, "R11 commit");
        expect_ev(EV_IRQ, "R11 irq");
        pulse_eot();
        idle(2);
        req_check("R11 stopped", 0);
        set_en(0);
        idle(2);
        pol_dreq = 1; pol_dack = 1; pol_eot = 1; dack = 0; eot = 0;

        // OUT external EOT, 8-bit burst
        cfg_ack_only = 0; cfg_dir_in = 0; cfg_wide = 0;
        idle(1);
        set_en(1);
        idle(3);
        expect_ev(EV_RD, "R7 rd");
        strobe(1, 0, 1, 1, "R7 stays active in burst");
        expect_ev(EV_FLUSH, "R10 flush");
        expect_ev(EV_IRQ, "R10 irq");
        pulse_eot();
        idle(2);
        req_check("R10 stopped", 0);
        strobe(1, 0, 1, 0, "R10 no transfer after eot");
        set_en(0);
        idle(2);

        // Short packet
        cfg_short_en = 1; buf_short = 1; buf_last = 1;
        set_en(1);
        idle(3);
        expect_ev(EV_RD, "R12 rd");
        expect_ev(EV_IRQ, "R12 short irq");
        strobe(1, 0, 1, 0, "R12 short ends run");
        idle(2);
        req_check("R12 halted", 0);
        set_en(0);
        idle(2);
        cfg_short_en = 0;
        set_en(1);
        idle(3);
        expect_ev(EV_RD, "R12 rd no short eot");
        strobe(1, 0, 1, 1, "R12 short disabled continues");
        set_en(0);
        idle(2);
        buf_short = 0; buf_last = 0;

        // 16-bit IN, counter end mid-buffer
        cfg_dir_in = 1; cfg_wide = 1; cfg_burst = 0; cfg_cnt_en = 1; cfg_count = 6;
        set_en(1);
        idle(3);
        expect_ev(EV_WR, "R8 wr");
        strobe(0, 1, 1, 0, "R6 drop");
        expect_ev(EV_WR, "R8 wr");
        strobe(0, 1, 1, 0, "R6 drop");
        expect_ev(EV_WR, "R8 wr");
        expect_ev(EV_COMMIT, "R9 partial commit");
        expect_ev(EV_IRQ, "R8 irq");
        strobe(0, 1, 1, 0, "R8 word count end");
        set_en(0);
        idle(2);
        cfg_count = 4; buf_last = 1;
        set_en(1);
        idle(3);
        expect_ev(EV_WR, "R9 wr");
        strobe(0, 1, 1, 0, "R6 drop");
        expect_ev(EV_WR, "R9 wr");
        expect_ev(EV_IRQ, "R9 irq without commit");
        strobe(0, 1, 1, 0, "R9 full buffer end");
        set_en(0);
        idle(4);

        check("R1 all expected events seen", exp_code.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule